// File: doc/BRIEF.md
# Radio Clock Bring-Up Sequencer

This block brings a radio clock domain back to a known state after the reference clock has been reconfigured. A start request launches a fixed chain of steps. First it waits for the external clock synthesizer to report lock. It then pulses the reset of the on-chip clock PLL and waits for that PLL to lock. Next it pulses the reset of the radio-domain logic and waits for the input-delay calibration controller to report ready. Last, it pulses the converter resets: the ADC reset (active high) and the DAC reset (active low) assert together and release together.

Each wait is a lock gate with its own timeout, counted in ticks of a free-running millisecond strobe. After the last tick of a deadline the gate looks at its lock input once more. Only if that input is still low does the run stop, with an error code that names the failing gate. The whole chain, including every reset pulse, is skipped when both the previous and the requested clock source are internal.

All status inputs come from other clock domains, so each passes through a synchronizer before it is used. The synchronized values are published as a status word. A combined reference-locked flag is the AND of the three lock conditions.

Top module: `refclk_bringup_seq`

## Requirements
- R1: While reset is held and after it is released, no reset output is asserted (dac_rst_n = 1, all others 0), and busy, done and err_code are all 0.
- R2: An accepted run follows this order: synthesizer lock gate, PLL reset pulse, PLL lock gate, radio reset pulse, delay-ready gate, converter pulse. It then ends with done = 1 and err_code = 0. busy is 1 from the cycle after the start is accepted until the run ends.
- R3: Each reset pulse lasts exactly PULSE_CYC clock cycles, and at most one reset group is asserted at any time. In the converter pulse, adc_rst = 1 and dac_rst_n = 0 hold together.
- R4: A gate whose lock stays low for its limit of ticks, and is still low at the final check, ends the run with done = 1. The error code is 1 for the synthesizer gate, 2 for the PLL gate and 3 for the delay gate, and no later reset pulse is issued.
- R5: A gate is passed if its synchronized lock input is high in the final-check cycle that follows the deadline's last tick, even though it was low up to the deadline.
- R6: When start_req is accepted with prev_src_int = 1 and next_src_int = 1, done = 1 and err_code = 0 on the next cycle, and no reset is pulsed.
- R7: With SYN_TMO_TICKS = 0, the synthesizer gate is bypassed: the PLL reset pulse begins on the cycle after the start, whatever the synthesizer lock input is.
- R8: A start_req that arrives while a run is in progress is ignored.
- R9: Every status input reaches clk_status two clock edges after it changes. The bit positions are: [1:0] synthesizer state, [2] synthesizer lock, [3] holdover, [4] pulse-per-second detect, [5] PLL lock, [6] delay-controller ready.
- R10: ref_locked equals clk_status[2] & clk_status[5] & clk_status[6].
- R11: done and err_code keep their values from the end of a run until the next accepted start, and done = 1 implies busy = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to run the sequence (taken only when idle) |
| prev_src_int | input | 1 | Clock source before the change was internal |
| next_src_int | input | 1 | Requested clock source is internal |
| tick_ms | input | 1 | One-cycle timebase strobe, about once per millisecond |
| syn_stat_a | input | 2 | Synthesizer state bits, asynchronous |
| syn_lock_a | input | 1 | Synthesizer lock, asynchronous |
| holdover_a | input | 1 | Synthesizer holdover, asynchronous |
| pps_a | input | 1 | Pulse-per-second detect, asynchronous |
| pll_lock_a | input | 1 | On-chip PLL lock, asynchronous |
| dly_rdy_a | input | 1 | Delay calibration controller ready, asynchronous |
| pll_rst | output | 1 | On-chip PLL reset pulse |
| radio_rst | output | 1 | Radio-domain logic reset pulse |
| adc_rst | output | 1 | ADC reset pulse, active high |
| dac_rst_n | output | 1 | DAC reset pulse, active low |
| clk_status | output | 7 | Synchronized status word |
| ref_locked | output | 1 | All three lock conditions are met |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has ended |
| err_code | output | 2 | 0 ok, 1 synthesizer, 2 PLL, 3 delay-controller timeout |

## Verification
The bench builds two instances that share one set of stimulus. The first uses PULSE_CYC = 4 with 3-tick limits on all three gates and a tick every 5 cycles, so that a timeout, and a lock that arrives right at the final check, are reached within a few dozen cycles. The second sets SYN_TMO_TICKS = 0. While the synthesizer lock is held low, this puts the bypassed chain next to a synthesizer timeout on the same run.

// File: rtl/bup_pkg.sv
package bup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SYN_WAIT,
        ST_SYN_LAST,
        ST_PLL_PULSE,
        ST_PLL_WAIT,
        ST_PLL_LAST,
        ST_RAD_PULSE,
        ST_DLY_WAIT,
        ST_DLY_LAST,
        ST_CNV_PULSE
    } bup_state_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_SYN  = 2'd1,
        ERR_PLL  = 2'd2,
        ERR_DLY  = 2'd3
    } bup_err_e;

    // Status word layout, software decodes these positions
    typedef struct packed {
        logic       dly_rdy;   // [6]
        logic       pll_lock;  // [5]
        logic       pps;       // [4]
        logic       holdover;  // [3]
        logic       syn_lock;  // [2]
        logic [1:0] syn_stat;  // [1:0]
    } clk_stat_t;

    localparam int STAT_W = $bits(clk_stat_t);

    function automatic int cw(input int n);
        int w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic is_wait(input bup_state_e s);
        return (s == ST_SYN_WAIT) || (s == ST_PLL_WAIT) || (s == ST_DLY_WAIT);
    endfunction

    function automatic logic is_pulse(input bup_state_e s);
        return (s == ST_PLL_PULSE) || (s == ST_RAD_PULSE) || (s == ST_CNV_PULSE);
    endfunction

    // Reset pulse that follows a passed gate
    function automatic bup_state_e pulse_after(input bup_state_e s);
        case (s)
            ST_SYN_WAIT, ST_SYN_LAST: return ST_PLL_PULSE;
            ST_PLL_WAIT, ST_PLL_LAST: return ST_RAD_PULSE;
            default:                  return ST_CNV_PULSE;
        endcase
    endfunction

    function automatic bup_state_e last_of(input bup_state_e s);
        case (s)
            ST_SYN_WAIT: return ST_SYN_LAST;
            ST_PLL_WAIT: return ST_PLL_LAST;
            default:     return ST_DLY_LAST;
        endcase
    endfunction

    function automatic bup_err_e err_of(input bup_state_e s);
        case (s)
            ST_SYN_LAST: return ERR_SYN;
            ST_PLL_LAST: return ERR_PLL;
            default:     return ERR_DLY;
        endcase
    endfunction

endpackage

// File: rtl/bup_sync.sv
module bup_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bup_deadline.sv
module bup_deadline #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt;
    logic [TW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + {{TW{1'b0}}, 1'b1};
    assign expire  = run && tick && (cnt_inc == {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= cnt_inc[TW-1:0];
    end
endmodule

// File: rtl/bup_pulse.sv
module bup_pulse #(
    parameter int PULSE = 16,
    parameter int PW    = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    logic [PW-1:0] cnt;

    assign last = run && (cnt == PW'(PULSE - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/refclk_bringup_seq.sv
module refclk_bringup_seq
    import bup_pkg::*;
#(
    parameter int PULSE_CYC     = 16,
    parameter int SYN_TMO_TICKS = 100,
    parameter int PLL_TMO_TICKS = 10,
    parameter int DLY_TMO_TICKS = 10,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       prev_src_int,
    input  logic       next_src_int,
    input  logic       tick_ms,
    input  logic [1:0] syn_stat_a,
    input  logic       syn_lock_a,
    input  logic       holdover_a,
    input  logic       pps_a,
    input  logic       pll_lock_a,
    input  logic       dly_rdy_a,
    output logic       pll_rst,
    output logic       radio_rst,
    output logic       adc_rst,
    output logic       dac_rst_n,
    output logic [6:0] clk_status,
    output logic       ref_locked,
    output logic       busy,
    output logic       done,
    output logic [1:0] err_code
);
    localparam int MAX_TMO = max3(SYN_TMO_TICKS, PLL_TMO_TICKS, DLY_TMO_TICKS);
    localparam int TW      = cw(MAX_TMO);
    localparam int PW      = cw(PULSE_CYC);

    bup_state_e    st_q, st_d;
    logic          done_q, done_d;
    bup_err_e      err_q, err_d;
    clk_stat_t     raw, stat_s;
    logic [STAT_W-1:0] stat_v;
    logic [TW-1:0] limit;
    logic          gate_ok, expire, pulse_last;

    // ---------------- synchronized status ----------------
    assign raw = {dly_rdy_a, pll_lock_a, pps_a, holdover_a, syn_lock_a, syn_stat_a};

    bup_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (stat_v)
    );
    assign stat_s     = clk_stat_t'(stat_v);
    assign clk_status = stat_s;
    assign ref_locked = stat_s.syn_lock & stat_s.pll_lock & stat_s.dly_rdy;

    // ---------------- gate selection ----------------
    always_comb begin
        case (st_q)
            ST_SYN_WAIT, ST_SYN_LAST: begin
                gate_ok = stat_s.syn_lock;
                limit   = TW'(SYN_TMO_TICKS);
            end
            ST_PLL_WAIT, ST_PLL_LAST: begin
                gate_ok = stat_s.pll_lock;
                limit   = TW'(PLL_TMO_TICKS);
            end
            ST_DLY_WAIT, ST_DLY_LAST: begin
                gate_ok = stat_s.dly_rdy;
                limit   = TW'(DLY_TMO_TICKS);
            end
            default: begin
                gate_ok = 1'b0;
                limit   = TW'(1);
            end
        endcase
    end

    bup_deadline #(.TW(TW)) u_deadline (
        .clk    (clk),
        .rst    (rst),
        .run    (is_wait(st_q)),
        .tick   (tick_ms),
        .limit  (limit),
        .expire (expire)
    );

    bup_pulse #(.PULSE(PULSE_CYC), .PW(PW)) u_pulse (
        .clk  (clk),
        .rst  (rst),
        .run  (is_pulse(st_q)),
        .last (pulse_last)
    );

    // ---------------- sequencing ----------------
    always_comb begin
        st_d   = st_q;
        done_d = done_q;
        err_d  = err_q;
        case (st_q)
            ST_IDLE: begin
                if (start_req) begin
                    err_d = ERR_NONE;
                    if (prev_src_int && next_src_int) begin
                        done_d = 1'b1;
                    end else begin
                        done_d = 1'b0;
                        st_d   = (SYN_TMO_TICKS == 0) ? ST_PLL_PULSE : ST_SYN_WAIT;
                    end
                end
            end
            ST_SYN_WAIT, ST_PLL_WAIT, ST_DLY_WAIT: begin
                if (gate_ok)     st_d = pulse_after(st_q);
                else if (expire) st_d = last_of(st_q);
            end
            ST_SYN_LAST, ST_PLL_LAST, ST_DLY_LAST: begin
                if (gate_ok) begin
                    st_d = pulse_after(st_q);
                end else begin
                    st_d   = ST_IDLE;
                    done_d = 1'b1;
                    err_d  = err_of(st_q);
                end
            end
            ST_PLL_PULSE: if (pulse_last) st_d = ST_PLL_WAIT;
            ST_RAD_PULSE: if (pulse_last) st_d = ST_DLY_WAIT;
            ST_CNV_PULSE: begin
                if (pulse_last) begin
                    st_d   = ST_IDLE;
                    done_d = 1'b1;
                    err_d  = ERR_NONE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b0;
            err_q  <= ERR_NONE;
        end else begin
            st_q   <= st_d;
            done_q <= done_d;
            err_q  <= err_d;
        end
    end

    assign pll_rst   = (st_q == ST_PLL_PULSE);
    assign radio_rst = (st_q == ST_RAD_PULSE);
    assign adc_rst   = (st_q == ST_CNV_PULSE);
    assign dac_rst_n = (st_q != ST_CNV_PULSE);
    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;
    assign err_code  = err_q;

    // ---------------- assertions ----------------
    logic any_rst;
    int   hi_len;
    assign any_rst = pll_rst | radio_rst | adc_rst;

    always_ff @(posedge clk) begin
        if (rst || !any_rst) hi_len <= 0;
        else                 hi_len <= hi_len + 1;
    end

    AST_ONE_RESET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pll_rst, radio_rst, adc_rst})); // R3
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(any_rst) |-> (hi_len == PULSE_CYC)); // R3
    AST_ORDER_RAD: assert property (@(posedge clk) disable iff (rst)
        $rose(radio_rst) |-> $past(clk_status[5])); // R2
    AST_ORDER_CNV: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_rst) |-> $past(clk_status[6])); // R2
    AST_ERR_DONE: assert property (@(posedge clk) disable iff (rst)
        (err_code != 2'd0) |-> done); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R11
    AST_SKIP_RUN: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_req && prev_src_int && next_src_int)
        |=> (done && !busy && err_code == 2'd0)); // R6
    AST_LOCK_AND: assert property (@(posedge clk) disable iff (rst)
        ref_locked == (clk_status[2] && clk_status[5] && clk_status[6])); // R10

    if (SYN_TMO_TICKS != 0) begin : g_syn_gate
        AST_ORDER_PLL: assert property (@(posedge clk) disable iff (rst)
            $rose(pll_rst) |-> $past(clk_status[2])); // R2
    end else begin : g_syn_bypass
        AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
            (!busy && start_req && !(prev_src_int && next_src_int)) |=> pll_rst); // R7
    end
endmodule

// File: tb/test_refclk_bringup_seq.sv
module test_refclk_bringup_seq;
    localparam int PULSE = 4;
    localparam int SYN   = 3;
    localparam int PLL   = 3;
    localparam int DLY   = 3;
    localparam int TP    = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1, start_req = 1'b0, prev_int = 1'b0, next_int = 1'b0, tick = 1'b0;
    logic [1:0] syn_stat = 2'b00;
    logic       syn_lock = 1'b0, holdover = 1'b0, pps = 1'b0, pll_lock = 1'b0, dly_rdy = 1'b0;

    logic [1:0] o_pll, o_rad, o_adc, o_dacn, o_ref, o_busy, o_done;
    logic [1:0] o_err [2];
    logic [6:0] o_stat [2];

    refclk_bringup_seq #(.PULSE_CYC(PULSE), .SYN_TMO_TICKS(SYN), .PLL_TMO_TICKS(PLL),
                         .DLY_TMO_TICKS(DLY), .SYNC_STAGES(2)) i_refclk_bringup_seq (
        .clk(clk), .rst(rst), .start_req(start_req), .prev_src_int(prev_int), .next_src_int(next_int),
        .tick_ms(tick), .syn_stat_a(syn_stat), .syn_lock_a(syn_lock), .holdover_a(holdover),
        .pps_a(pps), .pll_lock_a(pll_lock), .dly_rdy_a(dly_rdy),
        .pll_rst(o_pll[0]), .radio_rst(o_rad[0]), .adc_rst(o_adc[0]), .dac_rst_n(o_dacn[0]),
        .clk_status(o_stat[0]), .ref_locked(o_ref[0]), .busy(o_busy[0]), .done(o_done[0]),
        .err_code(o_err[0]));

    refclk_bringup_seq #(.PULSE_CYC(PULSE), .SYN_TMO_TICKS(0), .PLL_TMO_TICKS(PLL),
                         .DLY_TMO_TICKS(DLY), .SYNC_STAGES(2)) i_refclk_bringup_seq_nosyn (
        .clk(clk), .rst(rst), .start_req(start_req), .prev_src_int(prev_int), .next_src_int(next_int),
        .tick_ms(tick), .syn_stat_a(syn_stat), .syn_lock_a(syn_lock), .holdover_a(holdover),
        .pps_a(pps), .pll_lock_a(pll_lock), .dly_rdy_a(dly_rdy),
        .pll_rst(o_pll[1]), .radio_rst(o_rad[1]), .adc_rst(o_adc[1]), .dac_rst_n(o_dacn[1]),
        .clk_status(o_stat[1]), .ref_locked(o_ref[1]), .busy(o_busy[1]), .done(o_done[1]),
        .err_code(o_err[1]));

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0, model_ok = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    // phase: 0 idle, 1/4/7 gate wait, 2/5/8 final check, 3/6/9 reset pulse (pll, radio, converters)
    int ph [2] = '{0, 0};
    int tc [2] = '{0, 0};
    int pc [2] = '{0, 0};
    int md [2] = '{0, 0};
    int me [2] = '{0, 0};
    int lim_syn [2] = '{SYN, 0};
    logic [6:0] s1 = '0, s2 = '0;
    int n_pll, n_rad, n_adc, r_pll, c_pll, c_rad, c_adc;
    logic p_pll, p_rad, p_adc;

    function automatic int gate_bit(input int p);
        return (p <= 2) ? 2 : (p <= 5) ? 5 : 6;
    endfunction

    task automatic step(input int i);
        int p, lim;
        bit g;
        p = ph[i];
        g = s2[gate_bit(p)];
        if (rst) begin
            ph[i] = 0; tc[i] = 0; pc[i] = 0; md[i] = 0; me[i] = 0;
        end else begin
            case (p)
                0: if (start_req) begin
                    me[i] = 0;
                    if (prev_int && next_int) md[i] = 1;
                    else begin md[i] = 0; ph[i] = (lim_syn[i] == 0) ? 3 : 1; tc[i] = 0; pc[i] = 0; end
                end
                1, 4, 7: begin
                    lim = (p == 1) ? lim_syn[i] : (p == 4) ? PLL : DLY;
                    if (g) begin ph[i] = p + 2; tc[i] = 0; end
                    else if (tick) begin
                        if (tc[i] == lim - 1) begin ph[i] = p + 1; tc[i] = 0; end
                        else tc[i]++;
                    end
                end
                2, 5, 8: if (g) ph[i] = p + 1;
                         else begin ph[i] = 0; md[i] = 1; me[i] = (p == 2) ? 1 : (p == 5) ? 2 : 3; end
                default: if (pc[i] == PULSE - 1) begin
                    pc[i] = 0;
                    if (p == 9) begin ph[i] = 0; md[i] = 1; me[i] = 0; end
                    else ph[i] = p + 1;
                end else pc[i]++;
            endcase
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        // run observation of instance A (values held during the cycle that ends now)
        if (start_req && !o_busy[0]) begin
            n_pll = 0; n_rad = 0; n_adc = 0; r_pll = 0; c_pll = 0; c_rad = 0; c_adc = 0;
        end else begin
            if (o_pll[0]) n_pll++;
            if (o_rad[0]) n_rad++;
            if (o_adc[0]) n_adc++;
            if (o_pll[0] && !p_pll) begin r_pll++; c_pll = cyc; end
            if (o_rad[0] && !p_rad) c_rad = cyc;
            if (o_adc[0] && !p_adc) c_adc = cyc;
        end
        p_pll = o_pll[0]; p_rad = o_rad[0]; p_adc = o_adc[0];
        step(0);
        step(1);
        if (rst) begin s1 = '0; s2 = '0; end
        else begin s2 = s1; s1 = {dly_rdy, pll_lock, pps, holdover, syn_lock, syn_stat}; end
        model_ok = 1;
    end

    always @(negedge clk) tick <= ((cyc + 1) % TP == 0);

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (model_ok) begin
            for (int i = 0; i < 2; i++) begin
                chk(o_pll[i] == (ph[i] == 3), "R2", "pll_rst", o_pll[i], ph[i] == 3);
                chk(o_rad[i] == (ph[i] == 6), "R2", "radio_rst", o_rad[i], ph[i] == 6);
                chk(o_adc[i] == (ph[i] == 9), "R3", "adc_rst", o_adc[i], ph[i] == 9);
                chk(o_dacn[i] == (ph[i] != 9), "R3", "dac_rst_n", o_dacn[i], ph[i] != 9);
                chk(o_busy[i] == (ph[i] != 0), "R8", "busy", o_busy[i], ph[i] != 0);
                chk(o_done[i] == md[i][0], "R11", "done", o_done[i], md[i]);
                chk(int'(o_err[i]) == me[i], "R4", "err_code", o_err[i], me[i]);
                chk(o_stat[i] == s2, "R9", "clk_status", o_stat[i], s2);
                chk(o_ref[i] == (s2[2] & s2[5] & s2[6]), "R10", "ref_locked", o_ref[i], s2[2] & s2[5] & s2[6]);
            end
        end
    end

    task automatic run(input bit restart);
        @(negedge clk) start_req = 1;
        @(negedge clk) start_req = 0;
        if (restart) begin
            @(negedge clk) start_req = 1;
            @(negedge clk) start_req = 0;
        end
        for (int k = 0; k < 400; k++) begin
            if (o_done[0] && o_done[1]) break;
            @(negedge clk);
        end
    endtask

    task automatic set_locks(input bit sy, input bit pl, input bit dl);
        @(negedge clk);
        syn_lock = sy; pll_lock = pl; dly_rdy = dl;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(o_pll[0] == 0 && o_rad[0] == 0 && o_adc[0] == 0, "R1", "resets in reset", o_pll[0], 0);
        chk(o_dacn[0] == 1, "R1", "dac_rst_n in reset", o_dacn[0], 1);
        rst = 0;
        @(negedge clk);
        chk(o_busy[0] == 0 && o_done[0] == 0, "R1", "busy/done after reset", o_busy[0] | o_done[0], 0);
        chk(o_err[0] == 0, "R1", "err after reset", o_err[0], 0);

        // R6 skip when both internal
        prev_int = 1; next_int = 1;
        run(0);
        chk(o_done[0] == 1 && o_busy[0] == 0, "R6", "skip done", o_done[0], 1);
        chk(o_err[0] == 0, "R6", "skip err", o_err[0], 0);
        chk(n_pll + n_rad + n_adc == 0, "R6", "skip pulses", n_pll + n_rad + n_adc, 0);
        prev_int = 0;

        // R2/R3/R8 full sequence with a second start mid-run
        set_locks(1, 1, 1);
        run(1);
        chk(o_err[0] == 0 && o_done[0] == 1, "R2", "success err", o_err[0], 0);
        chk(c_pll < c_rad && c_rad < c_adc, "R2", "pulse order pll<radio", c_pll, c_rad);
        chk(n_pll == PULSE, "R3", "pll pulse length", n_pll, PULSE);
        chk(n_rad == PULSE, "R3", "radio pulse length", n_rad, PULSE);
        chk(n_adc == PULSE, "R3", "converter pulse length", n_adc, PULSE);
        chk(r_pll == 1, "R8", "single pll pulse despite restart", r_pll, 1);

        // R4 PLL gate timeout
        set_locks(1, 0, 1);
        run(0);
        chk(o_err[0] == 2, "R4", "pll timeout code", o_err[0], 2);
        chk(n_rad == 0 && n_adc == 0, "R4", "no later pulse after pll timeout", n_rad + n_adc, 0);
        repeat (10) @(negedge clk);
        chk(o_err[0] == 2 && o_done[0] == 1, "R11", "err held", o_err[0], 2);

        // R4 delay gate timeout
        set_locks(1, 1, 0);
        run(0);
        chk(o_err[0] == 3, "R4", "delay timeout code", o_err[0], 3);
        chk(n_adc == 0, "R4", "no converter pulse", n_adc, 0);

        // R4 synth timeout on A, R7 bypass on B
        set_locks(0, 1, 1);
        run(0);
        chk(o_err[0] == 1, "R4", "synth timeout code", o_err[0], 1);
        chk(n_pll == 0, "R4", "no pll pulse after synth timeout", n_pll, 0);
        chk(o_err[1] == 0 && o_done[1] == 1, "R7", "bypassed synth gate completes", o_err[1], 0);

        // R5 lock arrives only for the final check
        set_locks(1, 0, 1);
        @(negedge clk) start_req = 1;
        @(negedge clk) start_req = 0;
        for (int k = 0; k < 300; k++) begin
            if (ph[0] == 4 && tc[0] == PLL - 1 && ((cyc + 2) % TP == 0)) begin
                pll_lock = 1;
                break;
            end
            @(negedge clk);
        end
        for (int k = 0; k < 400; k++) begin
            if (o_done[0] && o_done[1]) break;
            @(negedge clk);
        end
        chk(o_err[0] == 0, "R5", "final check passes gate", o_err[0], 0);
        chk(n_adc == PULSE, "R5", "sequence completed after final check", n_adc, PULSE);

        // R9 synchronizer latency and bit position
        @(negedge clk) pps = 1;
        @(negedge clk);
        chk(o_stat[0][4] == 0, "R9", "pps after one edge", o_stat[0][4], 0);
        @(negedge clk);
        chk(o_stat[0][4] == 1, "R9", "pps after two edges", o_stat[0][4], 1);

        // R10 combined lock
        chk(o_ref[0] == 1, "R10", "all locked", o_ref[0], 1);
        @(negedge clk) dly_rdy = 0;
        repeat (2) @(negedge clk);
        chk(o_ref[0] == 0, "R10", "delay not ready", o_ref[0], 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule